// File: doc/BRIEF.md
# Masked Program Mapping Distributor

This block loads instruction words into the activation-frame stores of a two-dimensional array of processing elements (PEs). The default array is eight rows by eight columns, so there are 64 PEs. A host-side agent sends write requests. Each request carries a mode, a PE index, a 64-bit selection mask, a frame address and an instruction word.

For each accepted request the block raises the write-enable line of every chosen PE for exactly one cycle. At the same time it drives one shared address bus and one shared data bus that every PE sees. Which PEs are chosen depends on the mode:

- one PE picked by its index;
- every PE at once;
- only the PEs whose mask bit is set.

The request side uses a valid/ready handshake and can take a new request on every clock. Outputs are registered, so the pulse appears on the cycle after acceptance.

Top module: `prog_map_dist`

## Requirements
- R1: While reset is asserted, and on the first clock after it, all write enables and the error pulse are low and ready is low.
- R2: Mode code 2'b00 (single): the cycle after acceptance, exactly one write enable is high, the bit at position `req_idx`.
- R3: The single-mode index is formed as row*COLS + column, so row 0 column 0 is bit 0 and row ROWS-1 column COLS-1 is bit NPE-1.
- R4: Mode code 2'b01 (broadcast): the cycle after acceptance, all NPE write enables are high.
- R5: Mode code 2'b10 (masked): the cycle after acceptance, write enable bit i equals bit i of the accepted `req_mask`.
- R6: A masked request with an all-zero mask raises no write enable and no error.
- R7: Mode code 2'b11 raises `err_pulse` for one cycle the cycle after acceptance, and raises no write enable.
- R8: Whenever any write enable is high, `pe_addr` and `pe_data` equal the address and word of the request that caused it.
- R9: Write enables last one cycle only. A cycle with `req_valid` low produces no write enable and no error on the following cycle.
- R10: After reset, `req_ready` stays high, and requests on consecutive cycles each produce their own pulse on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_mode | input | 2 | 00 single, 01 broadcast, 10 masked, 11 illegal |
| req_idx | input | IDX_W (6) | Target PE index for single mode |
| req_mask | input | NPE (64) | PE selection mask for masked mode |
| req_addr | input | ADDR_W (8) | Frame-store address |
| req_data | input | DATA_W (32) | Instruction word |
| pe_we | output | NPE (64) | Per-PE write enables, one-cycle pulses |
| pe_addr | output | ADDR_W (8) | Shared frame-store address |
| pe_data | output | DATA_W (32) | Shared instruction word |
| err_pulse | output | 1 | One-cycle flag for an illegal mode code |

## Verification
The bench checks the end indices 0 and 63 and a middle row/column pair in single mode. An off-by-one in the index shift, or a swap of row and column, would light the wrong PE.

A masked request with an empty mask, and a request with mode 11, must both leave every enable low. A decoder that falls through to broadcast would write all 64 frame stores.

Requests are sent back to back, and then `req_valid` is dropped while a broadcast mode is still on the bus. A design that holds enables high, or that acts on a request without valid, would show stale or extra writes.

// File: rtl/prog_map_dist.sv
module prog_map_dist #(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [1:0]                        req_mode,
  input  logic [$clog2(ROWS*COLS)-1:0]      req_idx,
  input  logic [ROWS*COLS-1:0]              req_mask,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [DATA_W-1:0]                 req_data,
  output logic [ROWS*COLS-1:0]              pe_we,
  output logic [ADDR_W-1:0]                 pe_addr,
  output logic [DATA_W-1:0]                 pe_data,
  output logic                              err_pulse
);
  localparam int NPE   = ROWS * COLS;
  localparam int IDX_W = $clog2(NPE);
  localparam logic [1:0] M_ONE  = 2'b00;
  localparam logic [1:0] M_ALL  = 2'b01;
  localparam logic [1:0] M_MASK = 2'b10;

  logic           rdy_q;
  logic           take;
  logic [NPE-1:0] sel;
  logic [NPE-1:0] we_q;
  logic           err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign take      = req_valid && rdy_q;
  assign req_ready = rdy_q;
  assign pe_we     = we_q;
  assign pe_addr   = addr_q;
  assign pe_data   = data_q;
  assign err_pulse = err_q;

  always_comb begin
    case (req_mode)
      M_ONE:   sel = {{(NPE-1){1'b0}}, 1'b1} << req_idx;
      M_ALL:   sel = {NPE{1'b1}};
      M_MASK:  sel = req_mask;
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      we_q   <= '0;
      err_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      we_q  <= take ? sel : '0;
      err_q <= take && (req_mode == 2'b11);
      if (take) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end
  end

  assert_one_hot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode == M_ONE) |=> ($countones(pe_we) == 1 && pe_we[$past(req_idx)]));

  assert_all_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode == M_ALL) |=> (&pe_we));

  assert_mask_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode == M_MASK) |=> (pe_we == $past(req_mask)));

  assert_bad_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode == 2'b11) |=> (err_pulse && pe_we == '0));

  assert_bus_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pe_addr == $past(req_addr) && pe_data == $past(req_data)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (pe_we == '0 && !err_pulse));

  assert_ready_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);

  initial assert (IDX_W > 0);
endmodule

// File: tb/sim_prog_map_dist.sv
module sim_prog_map_dist;
  localparam int ROWS = 8, COLS = 8, AW = 8, DW = 32;
  localparam int NPE = ROWS * COLS;
  localparam int IW = $clog2(NPE);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [1:0] req_mode = 0;
  logic [IW-1:0] req_idx = 0;
  logic [NPE-1:0] req_mask = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_data = 0;
  logic [NPE-1:0] pe_we;
  logic [AW-1:0] pe_addr;
  logic [DW-1:0] pe_data;
  logic err_pulse;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  prog_map_dist #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_idx(req_idx), .req_mask(req_mask),
    .req_addr(req_addr), .req_data(req_data), .pe_we(pe_we),
    .pe_addr(pe_addr), .pe_data(pe_data), .err_pulse(err_pulse));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(string tag, bit v, logic [1:0] m, int row, int col,
                      logic [NPE-1:0] mk, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [NPE-1:0] exp_we;
    bit exp_err;
    @(negedge clk);
    chk({tag, " ready R10"}, 128'(req_ready), 128'(1));
    req_valid = v; req_mode = m; req_idx = IW'(row * COLS + col);
    req_mask = mk; req_addr = a; req_data = d;
    exp_we = '0;
    exp_err = 0;
    if (v) begin
      for (int i = 0; i < NPE; i++) begin
        if (m == 2'b00) exp_we[i] = (i == row * COLS + col);
        else if (m == 2'b01) exp_we[i] = 1'b1;
        else if (m == 2'b10) exp_we[i] = mk[i];
      end
      exp_err = (m == 2'b11);
    end
    @(posedge clk);
    #2;
    chk({tag, " we"}, 128'(pe_we), 128'(exp_we));
    chk({tag, " err"}, 128'(err_pulse), 128'(exp_err));
    if (exp_we != 0) begin
      chk({tag, " addr R8"}, 128'(pe_addr), 128'(a));
      chk({tag, " data R8"}, 128'(pe_data), 128'(d));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 we in reset", 128'(pe_we), 128'(0));
    chk("R1 err in reset", 128'(err_pulse), 128'(0));
    chk("R1 ready in reset", 128'(req_ready), 128'(0));
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    chk("R1 we after reset", 128'(pe_we), 128'(0));
    repeat (2) @(posedge clk);

    send("R2 R3 first PE",  1, 2'b00, 0, 0, '0, 8'h10, 32'hA000_0001);
    send("R2 R3 last PE",   1, 2'b00, ROWS-1, COLS-1, '0, 8'h11, 32'hA000_0002);
    send("R3 row3 col5",    1, 2'b00, 3, 5, '1, 8'h12, 32'hA000_0003);
    send("R3 row5 col3",    1, 2'b00, 5, 3, '0, 8'h13, 32'hA000_0004);
    send("R4 broadcast",    1, 2'b01, 2, 2, '0, 8'hFE, 32'hDEAD_BEEF);
    send("R5 mask pattern", 1, 2'b10, 0, 0, 64'h8000_0001_00F0_0A05, 8'h20, 32'h1234_5678);
    send("R5 mask single",  1, 2'b10, 0, 0, 64'h0000_0100_0000_0000, 8'h21, 32'h0BAD_F00D);
    send("R6 empty mask",   1, 2'b10, 1, 1, '0, 8'h22, 32'h5555_AAAA);
    send("R7 bad mode",     1, 2'b11, 4, 4, '1, 8'h23, 32'h7777_0000);
    send("R9 after error",  0, 2'b01, 0, 0, '1, 8'h24, 32'h0);
    send("R9 valid low",    0, 2'b01, 0, 0, '1, 8'h25, 32'h1);
    send("R10 b2b a",       1, 2'b00, 7, 0, '0, 8'h30, 32'h0000_0030);
    send("R10 b2b b",       1, 2'b10, 0, 0, 64'h00FF_0000_0000_FF00, 8'h31, 32'h0000_0031);
    send("R10 b2b c",       1, 2'b01, 0, 0, '0, 8'h32, 32'h0000_0032);
    send("R9 one cycle",    0, 2'b00, 0, 0, '0, 8'h00, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule